// File: doc/BRIEF.md
# Buffered Eight-Port Omega Switching Fabric

This block moves fixed-length cells from any of eight input ports to any of eight output ports through a three-stage omega network. In front of every stage, a perfect-shuffle link rotates each port index one bit to the left. Each stage then holds four 2x2 switch elements. Each element sends a cell to its upper or lower output from one bit of the cell's destination, starting at the most significant bit in the first stage. Each element has a queue on each of its two inputs. Every stage moves cells on every clock, so the stages work as a pipeline.

When two queue heads in one element want the same output, one waits in its queue and is not dropped. A small priority state machine in each element settles these conflicts. It has two states, PRI_UPPER and PRI_LOWER, and is reset to PRI_UPPER. Transition UPPER_WINS (PRI_UPPER to PRI_LOWER) fires when the upper input gets a contested output. Transition LOWER_WINS (PRI_LOWER to PRI_UPPER) fires when the lower input gets it. In every other cycle the state holds. A stage passes a cell on only when the queue ahead of it has room, so cells are never lost inside the fabric. A cell is lost only when it arrives at a first-stage queue that is full. The outputs are taken away at once and never stall. Three saturating counters record cells offered, delivered and dropped at entry.

Top module: `omega_fabric`

## Requirements
- R1: After reset every queue is empty, `out_valid` is all zero, all three counters read zero and `in_ready` is all ones.
- R2: A cell given destination `t` on `in_dest` (3 bits per port, the value is the output port number) leaves on output port `t` with its payload unchanged.
- R3: A cell offered in cycle c on an idle fabric shows on its output in cycle c+3 for exactly one cycle.
- R4: `in_ready[i]` is low exactly while the first-stage queue fed by port i is full. A cell offered then is dropped and counted as discarded. No cell is dropped after it has been accepted.
- R5: Each accepted cell is delivered exactly once. Each output carries at most one cell per cycle, and a cell that loses a conflict waits in its queue.
- R6: When both inputs of an element contend for one output, the winner alternates between the upper and the lower input from one won conflict to the next.
- R7: Cells from one input port to one output port leave in the order they were offered.
- R8: `offered_cnt` grows by the number of valid inputs per cycle, `delivered_cnt` by the number of valid outputs and `discarded_cnt` by the number of entry drops. Once the fabric has drained, offered equals delivered plus discarded.
- R9: Each counter stops at its all-ones value instead of wrapping.
- R10: `cnt_clr` zeroes all three counters at the next clock edge and takes priority over counting in that cycle. Cells held in the fabric are not affected.
- R11: The identity pattern (every port to itself at once) meets no conflict: all eight cells arrive in the same cycle, three cycles after they are offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, empties all queues |
| cnt_clr | input | 1 | Synchronous clear of the three counters |
| in_valid | input | N_PORTS | Cell present on each input port |
| in_dest | input | N_PORTS*log2(N_PORTS) | Destination port number per input, port i at bits [3i+2:3i] |
| in_data | input | N_PORTS*DATA_W | Cell payload per input |
| in_ready | output | N_PORTS | Entry queue has room; a cell offered while low is dropped |
| out_valid | output | N_PORTS | Cell delivered on each output port this cycle |
| out_data | output | N_PORTS*DATA_W | Delivered payload per output |
| offered_cnt | output | CNT_W | Cells offered at the inputs |
| delivered_cnt | output | CNT_W | Cells delivered at the outputs |
| discarded_cnt | output | CNT_W | Cells dropped at entry |

## Verification
The hardest condition to reach from the ports is a contested element whose arbiter keeps changing state. Random traffic seldom keeps two queue heads fighting over one output for several cycles running. The bench drives ports 0 and 4 to destination 0 on consecutive cycles, because these two ports share a first-stage element. It then checks that the sources alternate at output 0. To force entry drops and stalls between stages, a hotspot burst sends every port to one destination. This fills queues all along the path. Counter saturation is reached with narrow counters in the bench and a long flood of traffic.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Arbitration priority of one 2x2 element
    typedef enum logic {
        PRI_UPPER = 1'b0,
        PRI_LOWER = 1'b1
    } pri_e;

    // Perfect-shuffle position: one-bit left rotation of idx over 'bits' bits
    function automatic int rotl_pos(input int idx, input int bits);
        int msb;
        msb = (idx >> (bits - 1)) & 1;
        return ((idx << 1) & ((1 << bits) - 1)) | msb;
    endfunction

endpackage

// File: rtl/omega_fifo.sv
module omega_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST     = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [LVL_W-1:0] level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign dout  = mem[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == FULL_LVL);

    // R4: the upstream side never writes into a full queue
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R5: a cell is only removed when one is held
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int CELL_W    = 19,
    parameter int ROUTE_POS = 18,
    parameter int DEPTH     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          in_vld,
    input  logic [2*CELL_W-1:0] in_cell,
    output logic [1:0]          in_rdy,
    output logic [1:0]          out_vld,
    output logic [2*CELL_W-1:0] out_cell,
    input  logic [1:0]          out_rdy
);
    logic [1:0]        q_empty;
    logic [1:0]        q_full;
    logic [1:0]        pop;
    logic [1:0]        want;
    logic [CELL_W-1:0] head [2];

    for (genvar k = 0; k < 2; k++) begin : g_q
        omega_fifo #(.W(CELL_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_vld[k] && !q_full[k]),
            .din   (in_cell[k*CELL_W +: CELL_W]),
            .pop   (pop[k]),
            .dout  (head[k]),
            .empty (q_empty[k]),
            .full  (q_full[k])
        );
        assign in_rdy[k] = !q_full[k];
        assign want[k]   = head[k][ROUTE_POS];
    end

    pri_e pri_q;
    pri_e pri_d;
    logic clash;
    logic lower_first;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pri_q <= PRI_UPPER;
        else        pri_q <= pri_d;
    end

    // next state and grants
    always_comb begin
        clash       = !q_empty[0] && !q_empty[1] && (want[0] == want[1]);
        lower_first = (pri_q == PRI_LOWER);
        pri_d       = pri_q;
        unique case (pri_q)
            PRI_UPPER: if (clash && out_rdy[want[0]]) pri_d = PRI_LOWER; // UPPER_WINS
            PRI_LOWER: if (clash && out_rdy[want[1]]) pri_d = PRI_UPPER; // LOWER_WINS
        endcase
        pop[0] = !q_empty[0] && out_rdy[want[0]] && (!clash || !lower_first);
        pop[1] = !q_empty[1] && out_rdy[want[1]] && (!clash ||  lower_first);
    end

    // outputs
    always_comb begin
        out_vld  = '0;
        out_cell = '0;
        for (int o = 0; o < 2; o++) begin
            if (pop[0] && (want[0] == o[0])) begin
                out_vld[o]                   = 1'b1;
                out_cell[o*CELL_W +: CELL_W] = head[0];
            end else if (pop[1] && (want[1] == o[0])) begin
                out_vld[o]                   = 1'b1;
                out_cell[o*CELL_W +: CELL_W] = head[1];
            end
        end
    end

    // R5: both inputs never leave towards the same output together
    p_out_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop[0] && pop[1] && (want[0] == want[1])));

    // R6: a won conflict hands the next conflict to the other input
    p_alternate_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && pop[0]) |=> !(clash && pop[0]));
    p_alternate_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && pop[1]) |=> !(clash && pop[1]));

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N         = 8,
    parameter int LOG       = 3,
    parameter int CELL_W    = 19,
    parameter int ROUTE_POS = 18,
    parameter int DEPTH     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        in_vld,
    input  logic [N*CELL_W-1:0] in_cell,
    output logic [N-1:0]        in_rdy,
    output logic [N-1:0]        out_vld,
    output logic [N*CELL_W-1:0] out_cell,
    input  logic [N-1:0]        out_rdy
);
    logic [N-1:0]        sh_vld;
    logic [N-1:0]        sh_rdy;
    logic [N*CELL_W-1:0] sh_cell;

    // perfect-shuffle link into the switch column
    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int J = rotl_pos(i, LOG);
        assign sh_vld[J]                  = in_vld[i];
        assign sh_cell[J*CELL_W +: CELL_W] = in_cell[i*CELL_W +: CELL_W];
        assign in_rdy[i]                  = sh_rdy[J];
    end

    for (genvar j = 0; j < N/2; j++) begin : g_sw
        omega_switch #(
            .CELL_W    (CELL_W),
            .ROUTE_POS (ROUTE_POS),
            .DEPTH     (DEPTH)
        ) u_sw (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (sh_vld[2*j +: 2]),
            .in_cell  (sh_cell[2*j*CELL_W +: 2*CELL_W]),
            .in_rdy   (sh_rdy[2*j +: 2]),
            .out_vld  (out_vld[2*j +: 2]),
            .out_cell (out_cell[2*j*CELL_W +: 2*CELL_W]),
            .out_rdy  (out_rdy[2*j +: 2])
        );
    end

endmodule

// File: rtl/omega_sat_counter.sv
module omega_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     value
);
    localparam int SW = W + 1;
    localparam logic [W-1:0] TOP = '1;

    logic [W:0] sum;
    assign sum = {1'b0, value} + SW'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= '0;
        else if (clr)    value <= '0;
        else if (sum[W]) value <= TOP;
        else             value <= sum[W-1:0];
    end

    // R10: clear wins over counting
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));

    // R9: a full counter stays full
    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && value == TOP) |=> (value == TOP));

    // R8: without clear the count never goes down
    p_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (value >= $past(value)));

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric
    import omega_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 4,
    parameter int CNT_W   = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cnt_clr,
    input  logic [N_PORTS-1:0]                    in_valid,
    input  logic [N_PORTS*$clog2(N_PORTS)-1:0]    in_dest,
    input  logic [N_PORTS*DATA_W-1:0]             in_data,
    output logic [N_PORTS-1:0]                    in_ready,
    output logic [N_PORTS-1:0]                    out_valid,
    output logic [N_PORTS*DATA_W-1:0]             out_data,
    output logic [CNT_W-1:0]                      offered_cnt,
    output logic [CNT_W-1:0]                      delivered_cnt,
    output logic [CNT_W-1:0]                      discarded_cnt
);
    localparam int LOG    = $clog2(N_PORTS);
    localparam int CELL_W = LOG + DATA_W;
    localparam int INC_W  = $clog2(N_PORTS + 1);

    logic [N_PORTS-1:0]        lvl_vld  [LOG+1];
    logic [N_PORTS-1:0]        lvl_rdy  [LOG+1];
    logic [N_PORTS*CELL_W-1:0] lvl_cell [LOG+1];

    // cell = {destination, payload}
    for (genvar i = 0; i < N_PORTS; i++) begin : g_pack
        assign lvl_cell[0][i*CELL_W +: CELL_W] =
            {in_dest[i*LOG +: LOG], in_data[i*DATA_W +: DATA_W]};
    end
    assign lvl_vld[0]   = in_valid;
    assign in_ready     = lvl_rdy[0];
    assign lvl_rdy[LOG] = '1;

    for (genvar s = 0; s < LOG; s++) begin : g_stage
        omega_stage #(
            .N         (N_PORTS),
            .LOG       (LOG),
            .CELL_W    (CELL_W),
            .ROUTE_POS (DATA_W + LOG - 1 - s),
            .DEPTH     (DEPTH)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (lvl_vld[s]),
            .in_cell  (lvl_cell[s]),
            .in_rdy   (lvl_rdy[s]),
            .out_vld  (lvl_vld[s+1]),
            .out_cell (lvl_cell[s+1]),
            .out_rdy  (lvl_rdy[s+1])
        );
    end

    assign out_valid = lvl_vld[LOG];
    for (genvar p = 0; p < N_PORTS; p++) begin : g_out
        assign out_data[p*DATA_W +: DATA_W] = lvl_cell[LOG][p*CELL_W +: DATA_W];

        // R2: whatever leaves port p was addressed to p
        p_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> (lvl_cell[LOG][p*CELL_W + DATA_W +: LOG] == LOG'(p)));
    end

    logic [INC_W-1:0] n_off;
    logic [INC_W-1:0] n_drop;
    logic [INC_W-1:0] n_del;
    assign n_off  = INC_W'($countones(in_valid));
    assign n_drop = INC_W'($countones(in_valid & ~lvl_rdy[0]));
    assign n_del  = INC_W'($countones(lvl_vld[LOG]));

    omega_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt_off (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (n_off),  .value (offered_cnt));
    omega_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt_del (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (n_del),  .value (delivered_cnt));
    omega_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt_drop (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (n_drop), .value (discarded_cnt));

endmodule

// File: tb/tb_omega_fabric.sv
module tb_omega_fabric;
    localparam int N     = 8;
    localparam int LOG   = 3;
    localparam int DW    = 24;
    localparam int DEPTH = 4;
    localparam int CW    = 12;
    localparam int CMAX  = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cnt_clr;
    logic [N-1:0]      in_valid;
    logic [N*LOG-1:0]  in_dest;
    logic [N*DW-1:0]   in_data;
    logic [N-1:0]      in_ready;
    logic [N-1:0]      out_valid;
    logic [N*DW-1:0]   out_data;
    logic [CW-1:0]     offered_cnt;
    logic [CW-1:0]     delivered_cnt;
    logic [CW-1:0]     discarded_cnt;

    // 20 time units per period: 50 MHz at 1 ns units
    always #10 clk = ~clk;

    omega_fabric #(.N_PORTS(N), .DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) dut (
        .clk (clk), .rst_n (rst_n), .cnt_clr (cnt_clr),
        .in_valid (in_valid), .in_dest (in_dest), .in_data (in_data), .in_ready (in_ready),
        .out_valid (out_valid), .out_data (out_data),
        .offered_cnt (offered_cnt), .delivered_cnt (delivered_cnt), .discarded_cnt (discarded_cnt));

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    bit pend     [4096];
    int send_cyc [4096];
    int arr_cyc  [4096];
    int last_seq [64];
    int seq_next = 0;
    int exp_off, exp_acc, exp_drop;
    int got_total = 0;
    bit track_on = 1'b1;
    bit trace_on = 1'b0;
    int trace [16];
    int trace_n = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // output monitor
    logic [DW-1:0] mon_d;
    int mon_src, mon_seq, mon_dst;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < N; p++) begin
                if (out_valid[p]) begin
                    mon_d   = out_data[p*DW +: DW];
                    mon_src = int'(mon_d[23:21]);
                    mon_seq = int'(mon_d[20:9]);
                    mon_dst = int'(mon_d[8:6]);
                    got_total++;
                    check(mon_dst == p, "R2", "output port of cell", p, mon_dst);
                    if (track_on) begin
                        check(pend[mon_seq], "R5", "cell delivered once", 0, 1);
                        pend[mon_seq]    = 1'b0;
                        arr_cyc[mon_seq] = cyc;
                        check(mon_seq > last_seq[mon_src*8 + mon_dst], "R7", "order per pair",
                              mon_seq, last_seq[mon_src*8 + mon_dst] + 1);
                        last_seq[mon_src*8 + mon_dst] = mon_seq;
                    end
                    if (trace_on && p == 0 && trace_n < 16) begin
                        trace[trace_n] = mon_src;
                        trace_n++;
                    end
                end
            end
        end
    end

    // one cycle of offered traffic
    task automatic drive(input logic [N-1:0] mask, input logic [N*LOG-1:0] dests);
        int s;
        @(negedge clk);
        for (int p = 0; p < N; p++) begin
            s = seq_next % 4096;
            in_valid[p]            = mask[p];
            in_dest[p*LOG +: LOG]  = dests[p*LOG +: LOG];
            in_data[p*DW +: DW]    = {3'(p), 12'(s), dests[p*LOG +: LOG], 6'd0};
            if (mask[p]) begin
                exp_off++;
                if (in_ready[p]) begin
                    exp_acc++;
                    if (track_on) begin
                        pend[s]     = 1'b1;
                        send_cyc[s] = cyc;
                    end
                end else begin
                    exp_drop++;
                end
                seq_next++;
            end
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = '0;
        end
    endtask

    function automatic logic [N*LOG-1:0] all_to(input int d);
        logic [N*LOG-1:0] v;
        for (int p = 0; p < N; p++) v[p*LOG +: LOG] = 3'(d);
        return v;
    endfunction

    function automatic int pending_count();
        int c = 0;
        for (int i = 0; i < 4096; i++) if (pend[i]) c++;
        return c;
    endfunction

    task automatic clear_counts();
        @(negedge clk);
        in_valid = '0;
        cnt_clr  = 1'b1;
        @(negedge clk);
        cnt_clr  = 1'b0;
        exp_off  = 0;
        exp_acc  = 0;
        exp_drop = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog R1 actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N*LOG-1:0] dv;
        logic [N-1:0]     mk;
        int s0, g_base, mix;
        void'($urandom(32'd7331));
        for (int i = 0; i < 64; i++) last_seq[i] = -1;
        rst_n = 1'b0; cnt_clr = 1'b0; in_valid = '0; in_dest = '0; in_data = '0;
        exp_off = 0; exp_acc = 0; exp_drop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == '1, "R1", "in_ready in reset", int'(in_ready), 255);
        check(offered_cnt == 0 && delivered_cnt == 0 && discarded_cnt == 0, "R1",
              "counters in reset", int'(offered_cnt), 0);
        rst_n = 1'b1;

        // single cell, port 2 to port 7
        dv = '0; dv[2*LOG +: LOG] = 3'd7;
        s0 = seq_next;
        drive(8'b0000_0100, dv);
        idle(8);
        check(!pend[s0], "R2", "single cell arrived", int'(pend[s0]), 0);
        check(arr_cyc[s0] - send_cyc[s0] == 3, "R3", "idle latency",
              arr_cyc[s0] - send_cyc[s0], 3);
        check(offered_cnt == 1 && delivered_cnt == 1 && discarded_cnt == 0, "R8",
              "single cell counts", int'(delivered_cnt), 1);

        // identity permutation
        for (int p = 0; p < N; p++) dv[p*LOG +: LOG] = 3'(p);
        s0 = seq_next;
        drive(8'hFF, dv);
        idle(8);
        for (int p = 0; p < N; p++)
            check(!pend[s0+p] && arr_cyc[s0+p] - send_cyc[s0+p] == 3, "R11",
                  "identity latency", arr_cyc[s0+p] - send_cyc[s0+p], 3);

        // ports 0 and 4 share a first-stage element and contend for output 0
        trace_on = 1'b1; trace_n = 0;
        repeat (4) drive(8'b0001_0001, all_to(0));
        idle(20);
        trace_on = 1'b0;
        check(trace_n == 8, "R6", "contended cells delivered", trace_n, 8);
        for (int k = 1; k < 8; k++)
            check(trace[k] != trace[k-1], "R6", "winner alternates", trace[k], 4 - trace[k-1]);

        // hotspot: every port to output 0
        repeat (20) drive(8'hFF, all_to(0));
        idle(250);
        check(exp_drop > 0, "R4", "hotspot caused entry drops", exp_drop, 1);
        check(int'(discarded_cnt) == exp_drop, "R4", "discarded count", int'(discarded_cnt), exp_drop);
        check(int'(offered_cnt) == exp_off, "R8", "offered count", int'(offered_cnt), exp_off);
        check(int'(delivered_cnt) == exp_acc, "R8", "delivered count", int'(delivered_cnt), exp_acc);
        check(pending_count() == 0, "R5", "no accepted cell lost", pending_count(), 0);

        // clear on an empty fabric, then constrained random traffic
        clear_counts();
        check(offered_cnt == 0 && delivered_cnt == 0 && discarded_cnt == 0, "R10",
              "counters cleared", int'(offered_cnt), 0);
        for (int c = 0; c < 500; c++) begin
            mix = int'($urandom % 100);
            mk  = '0;
            for (int p = 0; p < N; p++) begin
                mk[p] = (($urandom % 100) < 40);
                dv[p*LOG +: LOG] = (mix < 20) ? 3'd5 : 3'($urandom % 8);
            end
            drive(mk, dv);
        end
        idle(250);
        check(int'(offered_cnt) == exp_off, "R8", "random offered", int'(offered_cnt), exp_off);
        check(int'(delivered_cnt) == exp_acc, "R8", "random delivered", int'(delivered_cnt), exp_acc);
        check(int'(discarded_cnt) == exp_drop, "R4", "random discarded", int'(discarded_cnt), exp_drop);
        check(int'(offered_cnt) == int'(delivered_cnt) + int'(discarded_cnt), "R8",
              "conservation after drain", int'(offered_cnt),
              int'(delivered_cnt) + int'(discarded_cnt));
        check(pending_count() == 0, "R5", "random cells all delivered", pending_count(), 0);

        // clear while cells are held inside
        repeat (10) drive(8'hFF, all_to(3));
        @(negedge clk);
        in_valid = '0;
        cnt_clr  = 1'b1;
        #1 g_base = got_total;
        @(negedge clk);
        cnt_clr = 1'b0;
        #1;
        check(offered_cnt == 0 && delivered_cnt == 0 && discarded_cnt == 0, "R10",
              "clear with cells in flight", int'(delivered_cnt), 0);
        idle(250);
        check(int'(delivered_cnt) == got_total - g_base, "R10", "held cells counted after clear",
              int'(delivered_cnt), got_total - g_base);
        check(offered_cnt == 0, "R10", "no offers after clear", int'(offered_cnt), 0);
        check(pending_count() == 0, "R10", "held cells survive clear", pending_count(), 0);

        // saturation flood
        clear_counts();
        track_on = 1'b0;
        for (int c = 0; c < 600; c++) begin
            for (int p = 0; p < N; p++) dv[p*LOG +: LOG] = 3'($urandom % 8);
            drive(8'hFF, dv);
        end
        idle(4);
        check(int'(offered_cnt) == CMAX, "R9", "offered saturates", int'(offered_cnt), CMAX);
        check(int'(discarded_cnt) == ((exp_drop > CMAX) ? CMAX : exp_drop), "R9",
              "discarded follows or saturates", int'(discarded_cnt),
              (exp_drop > CMAX) ? CMAX : exp_drop);
        idle(250);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule